// File: doc/BRIEF.md
# Multi-channel ADC scan controller

This block sequences a sixteen-input, ten-bit analog-to-digital converter from a 32-bit register port. Software programs a control word (engine enable, a 3-bit operating mode and one enable bit per input) and a clock word (a divisor and a pre-divisor). While the engine is enabled in normal mode, the controller visits the enabled inputs one after another. It gives each one a sample slot whose length comes from the bus clock through the two-stage divider.

At the start of each slot the controller pulses a start strobe together with a 4-bit input index toward an external converter. The converter answers with a done pulse and a 10-bit value. The controller stores that value in a packed result word, two inputs per word. Results survive a stop, so software can read the last value of every input at any time.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset every register word reads zero, the engine is disabled in power-down mode (mode 0), and no start strobe occurs.
- R2: The control word is at byte offset 0x00: bit 0 enable, bits [3:1] mode, bit 16+n enables input n. Bits [15:4] read back as zero whatever was written.
- R3: Slots run only while enable is 1 and mode is 7 (normal). In mode 1 (standby), in mode 0, or with enable 0, no start strobe occurs.
- R4: The clock word is at byte offset 0x0C, with the divisor in bits [9:0] and the pre-divisor in bits [26:17]. Consecutive start strobes are 12 × 2 × (pre-divisor+1) × (divisor+1) bus cycles apart.
- R5: Enabled inputs are sampled in ascending index order, wrapping from the highest enabled input back to the lowest. Disabled inputs take no slot.
- R6: Results are read at byte offset 0x10 + (n/2)×4, even inputs in bits [9:0] and odd inputs in bits [25:16]. All other bits of a result word read zero.
- R7: A value is stored only when done arrives while its slot is still running. A slot with no done leaves the previous result in place.
- R8: Writes to result words have no effect.
- R9: A new clock word takes effect at the next slot boundary. The slot in progress keeps its length.
- R10: Clearing enable or leaving normal mode stops sequencing on the next edge and keeps all results. On restart, sampling begins at the lowest enabled input.
- R11: Each start strobe lasts exactly one cycle and carries the index of the input being sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 6 | Byte address of the register word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| convStart | output | 1 | One-cycle request to start a conversion |
| convChan | output | 4 | Input index of the requested conversion |
| convDone | input | 1 | Converter signals a valid result |
| convData | input | 10 | Converter result |

## Verification
The assertions check several properties on every cycle. A start strobe never lasts two cycles. No strobe follows a cycle in which the engine was not running. Every strobe names an input that was enabled. Result and control words keep their unused bits at zero. The stored results do not change while no slot is running. Other behaviours need the bench's scenarios: the exact slot spacing for a given divider setting, when a rewritten clock word takes effect, the wrap-around visiting order, the timeout when done never arrives, and writes that are ignored. The bench checks these against its cycle-level reference model.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  // Width of an input index; the design supports up to 16 inputs.
  localparam int CH_W = 4;

  // Strobes from the sequencer to the register datapath.
  typedef struct packed {
    logic            capEn;    // store convData this cycle
    logic [CH_W-1:0] capChan;  // result slot to update
  } scanStrobe_t;
endpackage

// File: rtl/adc_scan_datapath.sv
module adc_scan_datapath
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int RES_W    = 10,
  parameter int DIV_W    = 10,
  parameter int PRE_W    = 10,
  parameter int PRE_LSB  = 17,
  parameter int ADDR_W   = 6,
  parameter int MODE_RUN = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     busWe,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic [31:0]              busWdata,
  output logic [31:0]              busRdata,
  input  scanStrobe_t              strobe,
  input  logic [RES_W-1:0]         convData,
  output logic                     runEn,
  output logic [NUM_CH-1:0]        chanMask,
  output logic [PRE_W-1:0]         preDiv,
  output logic [DIV_W-1:0]         clkDiv,
  output logic [NUM_CH*RES_W-1:0]  resFlat
);
  localparam int WSEL_W  = ADDR_W - 2;
  localparam int NPAIR   = NUM_CH / 2;
  localparam int CTRL_IX = 0;
  localparam int CLK_IX  = 3;
  localparam int RES_IX  = 4;
  localparam logic [31:0] CTRL_MASK =
    (32'((64'd1 << NUM_CH) - 1) << 16) | 32'h0000_000F;
  localparam logic [31:0] CLK_MASK =
    (32'((64'd1 << PRE_W) - 1) << PRE_LSB) | 32'((64'd1 << DIV_W) - 1);

  logic [WSEL_W-1:0] wordSel;
  logic              aligned;
  logic [31:0]       ctrlReg;
  logic [31:0]       clkReg;
  logic [RES_W-1:0]  res [NUM_CH];

  assign wordSel = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrlReg <= '0;
      clkReg  <= '0;
    end else if (busWe && aligned) begin
      if (wordSel == WSEL_W'(CTRL_IX)) ctrlReg <= busWdata & CTRL_MASK;
      if (wordSel == WSEL_W'(CLK_IX))  clkReg  <= busWdata & CLK_MASK;
    end
  end

  assign runEn    = ctrlReg[0] && (ctrlReg[3:1] == 3'(MODE_RUN));
  assign chanMask = ctrlReg[16 +: NUM_CH];
  assign clkDiv   = clkReg[DIV_W-1:0];
  assign preDiv   = clkReg[PRE_LSB +: PRE_W];

  // One result register per input; only the sequencer strobe writes them.
  for (genvar g = 0; g < NUM_CH; g++) begin : g_res
    always_ff @(posedge clk) begin
      if (!rst_n)
        res[g] <= '0;
      else if (strobe.capEn && (strobe.capChan == CH_W'(g)))
        res[g] <= convData;
    end
    assign resFlat[g*RES_W +: RES_W] = res[g];
  end

  always_comb begin
    busRdata = '0;
    if (aligned) begin
      if (wordSel == WSEL_W'(CTRL_IX)) busRdata = ctrlReg;
      if (wordSel == WSEL_W'(CLK_IX))  busRdata = clkReg;
      for (int k = 0; k < NPAIR; k++) begin
        if (wordSel == WSEL_W'(RES_IX + k)) begin
          busRdata[RES_W-1:0]   = res[2*k];
          busRdata[16 +: RES_W] = res[2*k+1];
        end
      end
    end
  end
endmodule

// File: rtl/adc_scan_control.sv
module adc_scan_control
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DIV_W  = 10,
  parameter int PRE_W  = 10,
  parameter int TICKS  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              runEn,
  input  logic [NUM_CH-1:0] chanMask,
  input  logic [PRE_W-1:0]  preDiv,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic              convDone,
  output scanStrobe_t       strobe,
  output logic              convStart,
  output logic [CH_W-1:0]   convChan,
  output logic              slotBusy
);
  localparam int PER_W  = PRE_W + DIV_W + 2;
  localparam int TICK_W = $clog2(TICKS);

  logic              busy;
  logic [CH_W-1:0]   curChan;
  logic [PER_W-1:0]  perLen;   // bus cycles per conversion clock
  logic [PER_W-1:0]  cycCnt;   // first stage: bus cycles
  logic [TICK_W-1:0] tickCnt;  // second stage: conversion clocks
  logic              startQ;
  logic              found;
  logic [CH_W-1:0]   pick;
  logic              slotEnd;
  logic [PER_W-1:0]  newPer;

  // Next enabled input after curChan, circularly.
  always_comb begin
    found = 1'b0;
    pick  = curChan;
    for (int i = 1; i <= NUM_CH; i++) begin
      int idx;
      idx = (int'(curChan) + i) % NUM_CH;
      if (!found && chanMask[idx]) begin
        found = 1'b1;
        pick  = CH_W'(idx);
      end
    end
  end

  assign newPer  = (PER_W'(preDiv) + PER_W'(1)) * (PER_W'(clkDiv) + PER_W'(1)) * PER_W'(2);
  assign slotEnd = busy && (tickCnt == TICK_W'(TICKS-1)) && (cycCnt == perLen - PER_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      curChan <= CH_W'(NUM_CH-1);
      perLen  <= PER_W'(2);
      cycCnt  <= '0;
      tickCnt <= '0;
      startQ  <= 1'b0;
    end else if (!runEn || !found) begin
      busy    <= 1'b0;
      curChan <= CH_W'(NUM_CH-1);
      cycCnt  <= '0;
      tickCnt <= '0;
      startQ  <= 1'b0;
    end else if (!busy || slotEnd) begin
      busy    <= 1'b1;
      curChan <= pick;
      perLen  <= newPer;
      cycCnt  <= '0;
      tickCnt <= '0;
      startQ  <= 1'b1;
    end else begin
      startQ <= 1'b0;
      if (cycCnt == perLen - PER_W'(1)) begin
        cycCnt  <= '0;
        tickCnt <= tickCnt + TICK_W'(1);
      end else begin
        cycCnt <= cycCnt + PER_W'(1);
      end
    end
  end

  assign strobe.capEn   = busy && runEn && convDone;
  assign strobe.capChan = curChan;
  assign convStart      = startQ;
  assign convChan       = curChan;
  assign slotBusy       = busy;
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int RES_W   = 10,
  parameter int DIV_W   = 10,
  parameter int PRE_W   = 10,
  parameter int PRE_LSB = 17,
  parameter int ADDR_W  = 6,
  parameter int TICKS   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              convStart,
  output logic [CH_W-1:0]   convChan,
  input  logic              convDone,
  input  logic [RES_W-1:0]  convData
);
  scanStrobe_t             strobe;
  logic                    runEn;
  logic [NUM_CH-1:0]       chanMask;
  logic [PRE_W-1:0]        preDiv;
  logic [DIV_W-1:0]        clkDiv;
  logic [NUM_CH*RES_W-1:0] resFlat;
  logic                    slotBusy;

  adc_scan_datapath #(
    .NUM_CH(NUM_CH), .RES_W(RES_W), .DIV_W(DIV_W), .PRE_W(PRE_W),
    .PRE_LSB(PRE_LSB), .ADDR_W(ADDR_W), .MODE_RUN(7)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .strobe(strobe),
    .convData(convData), .runEn(runEn), .chanMask(chanMask),
    .preDiv(preDiv), .clkDiv(clkDiv), .resFlat(resFlat)
  );

  adc_scan_control #(
    .NUM_CH(NUM_CH), .DIV_W(DIV_W), .PRE_W(PRE_W), .TICKS(TICKS)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .runEn(runEn), .chanMask(chanMask),
    .preDiv(preDiv), .clkDiv(clkDiv), .convDone(convDone),
    .strobe(strobe), .convStart(convStart), .convChan(convChan),
    .slotBusy(slotBusy)
  );
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int RES_W  = 10,
  parameter int ADDR_W = 6
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    convStart,
  input logic [CH_W-1:0]         convChan,
  input logic                    runEn,
  input logic [NUM_CH-1:0]       chanMask,
  input logic                    slotBusy,
  input logic [NUM_CH*RES_W-1:0] resFlat,
  input logic [ADDR_W-1:0]       busAddr,
  input logic [31:0]             busRdata
);
  logic [NUM_CH-1:0] prevMask;
  logic              resWord;

  always_ff @(posedge clk) begin
    if (!rst_n) prevMask <= '0;
    else        prevMask <= chanMask;
  end

  assign resWord = (busAddr[1:0] == 2'b00) &&
                   (busAddr[ADDR_W-1:2] >= (ADDR_W-2)'(4)) &&
                   (busAddr[ADDR_W-1:2] <  (ADDR_W-2)'(4 + NUM_CH/2));

  // R11
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    convStart |=> !convStart);

  // R3
  idle_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !runEn |=> !convStart);

  // R5
  start_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    convStart |-> prevMask[convChan]);

  // R6
  res_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resWord |-> (busRdata[15:RES_W] == '0) && (busRdata[31:16+RES_W] == '0));

  // R2
  ctrl_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr == '0) |-> (busRdata[15:4] == '0));

  // R10
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slotBusy |=> $stable(resFlat));
endmodule

bind adc_scan_ctrl adc_scan_chk #(
  .NUM_CH(NUM_CH), .RES_W(RES_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .convStart(convStart), .convChan(convChan),
  .runEn(runEn), .chanMask(chanMask), .slotBusy(slotBusy),
  .resFlat(resFlat), .busAddr(busAddr), .busRdata(busRdata)
);

// File: tb/sim_adc_scan_ctrl.sv
`timescale 1ns/1ps
module sim_adc_scan_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busWe = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        convStart;
  logic [3:0]  convChan;
  logic        convDone = 1'b0;
  logic [9:0]  convData = '0;

  always #2 clk = ~clk;

  adc_scan_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .convStart(convStart),
    .convChan(convChan), .convDone(convDone), .convData(convData)
  );

  int nChk = 0;
  int nFail = 0;
  int cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic finishUp();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  endtask

  // ---------------- reference model ----------------
  logic [31:0] mCtrl, mClk;
  int mRes [16];
  int mPer, mCyc, mTick, mCur;
  bit mBusy, mStart;

  function automatic logic [31:0] rdModel(input logic [5:0] a);
    int w;
    if (a[1:0] != 0) return 0;
    w = a >> 2;
    if (w == 0) return mCtrl;
    if (w == 3) return mClk;
    if (w >= 4 && w < 12) return 32'(mRes[2*(w-4)]) | (32'(mRes[2*(w-4)+1]) << 16);
    return 0;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      mCtrl = 0; mClk = 0; mBusy = 0; mStart = 0; mCur = 15;
      mPer = 2; mCyc = 0; mTick = 0;
      foreach (mRes[i]) mRes[i] = 0;
    end else begin
      bit run;
      int mask, nxt;
      run  = mCtrl[0] && (mCtrl[3:1] == 3'd7);
      mask = int'(mCtrl[31:16]);
      if (mBusy && run && convDone) mRes[mCur] = int'(convData);
      nxt = -1;
      for (int i = 1; i <= 16; i++)
        if (nxt < 0 && mask[(mCur + i) % 16]) nxt = (mCur + i) % 16;
      if (!run || nxt < 0) begin
        mBusy = 0; mStart = 0; mCur = 15; mCyc = 0; mTick = 0;
      end else if (!mBusy || (mTick == 11 && mCyc == mPer - 1)) begin
        mBusy = 1; mStart = 1; mCur = nxt; mCyc = 0; mTick = 0;
        mPer = 2 * (((mClk >> 17) & 32'h3FF) + 1) * ((mClk & 32'h3FF) + 1);
      end else begin
        mStart = 0;
        if (mCyc == mPer - 1) begin mCyc = 0; mTick++; end
        else mCyc++;
      end
      if (busWe && busAddr == 6'h00) mCtrl = busWdata & 32'hFFFF_000F;
      if (busWe && busAddr == 6'h0C) mClk  = busWdata & 32'h07FE_03FF;
    end
    if (cyc >= 150000) begin
      chk(0, "watchdog", 0, 1);
      finishUp();
    end
  end

  // ---------------- converter responder ----------------
  bit  mute = 0;
  int  pend = 0;
  int  rChan = 0;
  int  seqN = 0;
  int  lastData [16];
  initial foreach (lastData[i]) lastData[i] = 0;

  always @(negedge clk) begin
    convDone = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0 && !mute) begin
        seqN++;
        convData = 10'(((rChan + 1) * 73 + seqN * 5) | 1);
        convDone = 1'b1;
        lastData[rChan] = int'(convData);
      end
    end
    if (convStart === 1'b1) begin pend = 5; rChan = int'(convChan); end
  end

  // ---------------- per-cycle comparison ----------------
  int startLog [$];
  int startTime [$];
  bit prevStart = 0;

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      // R11: strobe and index follow the model
      chk(convStart === mStart && (!mStart || convChan === 4'(mCur)), "R11 start",
          {27'd0, convStart, convChan}, {27'd0, mStart, 4'(mCur)});
      chk(!(prevStart && convStart), "R11 width", 32'(convStart), 0);
      // R2 R6: read data follows the model
      chk(busRdata === rdModel(busAddr), "R6 read", busRdata, rdModel(busAddr));
      if (convStart === 1'b1) begin
        startLog.push_back(int'(convChan));
        startTime.push_back(cyc);
      end
      prevStart = convStart;
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic waitStarts(input int n);
    for (int i = 0; i < 5000 && startLog.size() < n; i++) @(negedge clk);
  endtask

  localparam logic [31:0] MASK = 32'h8025_0000; // inputs 0, 2, 5, 15

  initial begin
    logic [31:0] v, v2;
    int exp8 [8] = '{0, 2, 5, 15, 0, 2, 5, 15};
    int tw;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1: everything reads zero after reset
    for (int k = 0; k < 16; k++) begin
      rd(6'(k*4), v);
      chk(v == 0, "R1 reset read", v, 0);
    end
    chk(convStart == 0, "R1 no start", 32'(convStart), 0);

    // R2: pad bits of the control word read zero; not running
    wr(6'h00, 32'h1234_FFF0);
    rd(6'h00, v);
    chk(v == 32'h1234_0000, "R2 ctrl readback", v, 32'h1234_0000);

    // R5 R4: ascending order with wrap, 24-cycle slots at minimum divider
    wr(6'h0C, 0);
    startLog.delete(); startTime.delete();
    wr(6'h00, MASK | 32'hF);
    waitStarts(8);
    for (int i = 0; i < 8; i++)
      chk(startLog[i] == exp8[i], "R5 order", startLog[i], exp8[i]);
    for (int i = 1; i < 8; i++)
      chk(startTime[i] - startTime[i-1] == 24, "R4 slot length",
          startTime[i] - startTime[i-1], 24);

    // R6: packing of captured values
    repeat (30) @(negedge clk);
    rd(6'h10, v);
    chk(v == 32'(lastData[0]), "R6 even field", v, lastData[0]);
    rd(6'h18, v);
    chk(v == (32'(lastData[5]) << 16), "R6 odd field", v, 32'(lastData[5]) << 16);
    rd(6'h2C, v);
    chk(v == (32'(lastData[15]) << 16), "R6 top pair", v, 32'(lastData[15]) << 16);

    // R9 R4: new divider applies from the next slot boundary
    wr(6'h0C, (32'd1 << 17) | 32'd2);
    tw = cyc;
    startLog.delete(); startTime.delete();
    waitStarts(3);
    chk(startTime[0] - tw <= 24, "R9 current slot kept", startTime[0] - tw, 24);
    chk(startTime[1] - startTime[0] == 144, "R9 new length", startTime[1] - startTime[0], 144);
    chk(startTime[2] - startTime[1] == 144, "R4 scaled length", startTime[2] - startTime[1], 144);
    wr(6'h0C, 0);
    repeat (160) @(negedge clk);

    // R3: standby, and normal mode with enable cleared
    wr(6'h00, MASK | 32'h3);
    startLog.delete();
    repeat (300) @(negedge clk);
    chk(startLog.size() == 0, "R3 standby", startLog.size(), 0);
    wr(6'h00, MASK | 32'hE);
    repeat (300) @(negedge clk);
    chk(startLog.size() == 0, "R3 disabled", startLog.size(), 0);

    // R10: results kept after stop
    rd(6'h10, v);
    chk(v == 32'(lastData[0]), "R10 kept", v, lastData[0]);

    // R8: result writes ignored
    wr(6'h10, 32'hFFFF_FFFF);
    rd(6'h10, v2);
    chk(v2 == v, "R8 write ignored", v2, v);
    wr(6'h18, 32'h0000_0000);
    rd(6'h18, v2);
    chk(v2 == (32'(lastData[5]) << 16), "R8 write ignored odd", v2, 32'(lastData[5]) << 16);

    // R7 R10: no done keeps old value; restart at lowest enabled input
    mute = 1;
    startLog.delete();
    wr(6'h00, MASK | 32'hF);
    waitStarts(5);
    chk(startLog[0] == 0, "R10 restart lowest", startLog[0], 0);
    rd(6'h10, v2);
    chk(v2 == v, "R7 timeout keeps", v2, v);
    rd(6'h14, v2);
    chk(v2 == 32'(lastData[2]), "R7 timeout keeps ch2", v2, lastData[2]);

    // R5: clearing all input enables stops slots
    mute = 0;
    wr(6'h00, 32'hF);
    startLog.delete();
    repeat (100) @(negedge clk);
    chk(startLog.size() == 0, "R5 no enabled input", startLog.size(), 0);

    finishUp();
  end
endmodule